// File: doc/BRIEF.md
# Windowed Traffic Monitor with Threshold Zones

This block watches one path toward a memory subsystem and totals the bytes that cross it. Each transfer is reported by a strobe that carries a byte count. Time is divided into sample windows. A window is a programmed number of pulses from a fixed-rate reference timer. At the close of each window, the byte total is turned into a count of megabyte units. That count is then placed in one of four zones, using three programmed thresholds.

A zone raises its local interrupt status only after it has held for a programmed number of back-to-back windows. The block keeps the largest count seen in each zone. One global pending bit gathers all enabled local interrupts into a single interrupt line. Software uses the interrupt and the per-zone maxima to decide when the link speed should go up or down. It talks to the block through a simple register write and read port.

Top module: `trafmon_top`

## Requirements
- R1: The window register (0x2A8) holds a length L, where L=0 counts as 1. While monitoring is on, every pulse of `tick_i` advances the window position. The window closes on its L-th pulse, and the position then starts again from zero.
- R2: The count of a window is floor(bytes / 2^MB_SHIFT). Bytes are summed from the strobes accepted while monitoring is on. A strobe that arrives in the cycle where the window closes belongs to that closing window. The byte sum saturates at its maximum value instead of wrapping.
- R3: Zones are checked in this order: zone 1 if count >= high (0x2AC); otherwise zone 2 if count > medium (0x2B0); otherwise zone 3 if count > low (0x2B4); otherwise zone 0. Register 0x2D8, bits 1:0, holds the zone of the most recent window.
- R4: Register 0x2BC holds an 8-bit run limit for each zone n, at bits 8n+7:8n. A limit of 0 counts as 1. A run counter goes up for each window in the same zone as the one before it, and restarts at 1 when the zone changes. The status bit of zone n (bit 4+n of 0x100) sets in the window where the run counter equals the limit.
- R5: Writing 1 to bit 4+n of 0x108 clears the status of zone n and resets that zone's maximum to 0. If a set happens in the same cycle as the clear, the set wins.
- R6: Register 0x2E0+4n holds the largest count among zone-n windows since the last clear of that zone. It never decreases unless that zone is cleared.
- R7: The global pending bit (bit 0 of 0x000) is set while any local status bit is both set and enabled (enable bits 7:4 of 0x10C). Writing bit 0 of 0x008 clears it, but it sets again at once if an enabled local status is still pending. `irq_o` is the global pending bit ANDed with the global enable (bit 0 of 0x00C).
- R8: While bit 0 of 0x2A0 is 0, strobes and timer pulses are ignored and no window closes.
- R9: Writing 1 to bit 0 of 0x2A4 resets the byte sum and the window position to zero. Run counters and maxima are kept.
- R10: After reset every register reads 0, except 0x2B8. That register reads 0x95250901 and is plain read/write storage with no effect on behaviour.
- R11: Reads are combinational. Writable registers read back what was written. Clear registers and unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One pulse per reference-timer period |
| xfer_vld_i | input | 1 | Transfer strobe |
| xfer_bytes_i | input | BYTE_W | Bytes carried by the strobed transfer |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | ADDR_W | Register byte address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data (combinational) |
| irq_o | output | 1 | Global interrupt |

## Verification
The window close and a transfer strobe can fall in the same cycle. The bench forces this by setting a one-pulse window and holding the timer input high, so that every cycle closes a window. It then sends two different strobes in back-to-back cycles. Each strobe must be counted in full in its own window, and nowhere else. The bench judges this from the per-zone maxima: one window must land in zone 2 with count 9, and the other in zone 1 with count 13. A lost strobe, or one carried into the next window, would leave a different maximum behind.

// File: rtl/trafmon_pkg.sv
package trafmon_pkg;

   localparam int unsigned NZONE    = 4;
   localparam int unsigned STAT_LSB = 4;

   typedef enum logic [1:0] {
      ZN_IDLE = 2'd0,
      ZN_HIGH = 2'd1,
      ZN_MID  = 2'd2,
      ZN_LOW  = 2'd3
   } zone_e;

   localparam logic [11:0] A_GSTAT = 12'h000;
   localparam logic [11:0] A_GCLR  = 12'h008;
   localparam logic [11:0] A_GEN   = 12'h00C;
   localparam logic [11:0] A_LSTAT = 12'h100;
   localparam logic [11:0] A_LCLR  = 12'h108;
   localparam logic [11:0] A_LEN   = 12'h10C;
   localparam logic [11:0] A_RUN   = 12'h2A0;
   localparam logic [11:0] A_CCLR  = 12'h2A4;
   localparam logic [11:0] A_WIN   = 12'h2A8;
   localparam logic [11:0] A_THI   = 12'h2AC;
   localparam logic [11:0] A_TMID  = 12'h2B0;
   localparam logic [11:0] A_TLO   = 12'h2B4;
   localparam logic [11:0] A_ACT   = 12'h2B8;
   localparam logic [11:0] A_RLIM  = 12'h2BC;
   localparam logic [11:0] A_LZONE = 12'h2D8;
   localparam logic [11:0] A_MAX0  = 12'h2E0;

   localparam logic [31:0] ACT_RST = 32'h9525_0901;

endpackage

// File: rtl/trafmon_regs.sv
module trafmon_regs
   import trafmon_pkg::*;
#(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned WIN_W  = 32
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    we_i,
   input  logic [ADDR_W-1:0]       addr_i,
   input  logic [DATA_W-1:0]       wdata_i,
   output logic [DATA_W-1:0]       rdata_o,
   output logic                    mon_en_o,
   output logic [WIN_W-1:0]        win_len_o,
   output logic [CNT_W-1:0]        thr_hi_o,
   output logic [CNT_W-1:0]        thr_mid_o,
   output logic [CNT_W-1:0]        thr_lo_o,
   output logic [31:0]             run_lim_o,
   output logic [NZONE-1:0]        loc_en_o,
   output logic                    glob_en_o,
   output logic [NZONE-1:0]        loc_clr_o,
   output logic                    glob_clr_o,
   output logic                    cnt_clr_o,
   input  logic [NZONE-1:0]        loc_stat_i,
   input  logic                    glob_stat_i,
   input  logic [1:0]              last_zone_i,
   input  logic [NZONE*CNT_W-1:0]  zmax_i
);

   localparam int unsigned SL = STAT_LSB;

   logic [31:0] act_q;

   function automatic logic hit(input logic [11:0] a);
      return we_i && (addr_i == ADDR_W'(a));
   endfunction

   assign loc_clr_o  = hit(A_LCLR) ? wdata_i[SL+NZONE-1:SL] : '0;
   assign glob_clr_o = hit(A_GCLR) & wdata_i[0];
   assign cnt_clr_o  = hit(A_CCLR) & wdata_i[0];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mon_en_o  <= 1'b0;
         win_len_o <= '0;
         thr_hi_o  <= '0;
         thr_mid_o <= '0;
         thr_lo_o  <= '0;
         run_lim_o <= '0;
         loc_en_o  <= '0;
         glob_en_o <= 1'b0;
         act_q     <= ACT_RST;
      end else if (we_i) begin
         if (hit(A_RUN))  mon_en_o  <= wdata_i[0];
         if (hit(A_WIN))  win_len_o <= wdata_i[WIN_W-1:0];
         if (hit(A_THI))  thr_hi_o  <= wdata_i[CNT_W-1:0];
         if (hit(A_TMID)) thr_mid_o <= wdata_i[CNT_W-1:0];
         if (hit(A_TLO))  thr_lo_o  <= wdata_i[CNT_W-1:0];
         if (hit(A_RLIM)) run_lim_o <= wdata_i[31:0];
         if (hit(A_LEN))  loc_en_o  <= wdata_i[SL+NZONE-1:SL];
         if (hit(A_GEN))  glob_en_o <= wdata_i[0];
         if (hit(A_ACT))  act_q     <= wdata_i[31:0];
      end
   end

   always_comb begin
      rdata_o = '0;
      case (addr_i)
         ADDR_W'(A_GSTAT): rdata_o[0] = glob_stat_i;
         ADDR_W'(A_GEN):   rdata_o[0] = glob_en_o;
         ADDR_W'(A_LSTAT): rdata_o[SL+NZONE-1:SL] = loc_stat_i;
         ADDR_W'(A_LEN):   rdata_o[SL+NZONE-1:SL] = loc_en_o;
         ADDR_W'(A_RUN):   rdata_o[0] = mon_en_o;
         ADDR_W'(A_WIN):   rdata_o[WIN_W-1:0] = win_len_o;
         ADDR_W'(A_THI):   rdata_o[CNT_W-1:0] = thr_hi_o;
         ADDR_W'(A_TMID):  rdata_o[CNT_W-1:0] = thr_mid_o;
         ADDR_W'(A_TLO):   rdata_o[CNT_W-1:0] = thr_lo_o;
         ADDR_W'(A_ACT):   rdata_o[31:0] = act_q;
         ADDR_W'(A_RLIM):  rdata_o[31:0] = run_lim_o;
         ADDR_W'(A_LZONE): rdata_o[1:0] = last_zone_i;
         default: ;
      endcase
      for (int z = 0; z < NZONE; z++) begin
         if (addr_i == ADDR_W'(A_MAX0) + ADDR_W'(4 * z))
            rdata_o[CNT_W-1:0] = zmax_i[z*CNT_W +: CNT_W];
      end
   end

endmodule

// File: rtl/trafmon_window.sv
module trafmon_window #(
   parameter int unsigned BYTE_W   = 16,
   parameter int unsigned CNT_W    = 32,
   parameter int unsigned WIN_W    = 32,
   parameter int unsigned MB_SHIFT = 20
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              mon_en_i,
   input  logic              cnt_clr_i,
   input  logic              tick_i,
   input  logic              xfer_vld_i,
   input  logic [BYTE_W-1:0] xfer_bytes_i,
   input  logic [WIN_W-1:0]  win_len_i,
   output logic              win_done_o,
   output logic [CNT_W-1:0]  win_cnt_o
);

   localparam int unsigned ACC_W = CNT_W + MB_SHIFT;

   logic [ACC_W-1:0] acc_q;
   logic [WIN_W-1:0] pos_q;
   logic [ACC_W:0]   sum_raw;
   logic [ACC_W-1:0] sum_sat;
   logic [WIN_W-1:0] lim;
   logic             close_w;

   assign sum_raw = {1'b0, acc_q} + {1'b0, (xfer_vld_i ? ACC_W'(xfer_bytes_i) : ACC_W'(0))};
   assign sum_sat = sum_raw[ACC_W] ? '1 : sum_raw[ACC_W-1:0];
   assign lim     = (win_len_i == '0) ? WIN_W'(1) : win_len_i;
   assign close_w = mon_en_i && !cnt_clr_i && tick_i &&
                    (({1'b0, pos_q} + (WIN_W+1)'(1)) >= {1'b0, lim});

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         acc_q      <= '0;
         pos_q      <= '0;
         win_done_o <= 1'b0;
         win_cnt_o  <= '0;
      end else begin
         win_done_o <= close_w;
         if (close_w) win_cnt_o <= CNT_W'(sum_sat >> MB_SHIFT);
         if (cnt_clr_i) begin
            acc_q <= '0;
            pos_q <= '0;
         end else if (mon_en_i) begin
            acc_q <= close_w ? '0 : sum_sat;
            if (tick_i) pos_q <= close_w ? '0 : pos_q + WIN_W'(1);
         end
      end
   end

endmodule

// File: rtl/trafmon_zone.sv
module trafmon_zone
   import trafmon_pkg::*;
#(
   parameter int unsigned CNT_W = 32
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   win_done_i,
   input  logic [CNT_W-1:0]       win_cnt_i,
   input  logic [CNT_W-1:0]       thr_hi_i,
   input  logic [CNT_W-1:0]       thr_mid_i,
   input  logic [CNT_W-1:0]       thr_lo_i,
   input  logic [31:0]            run_lim_i,
   input  logic [NZONE-1:0]       max_clr_i,
   output logic [1:0]             zone_o,
   output logic [NZONE-1:0]       set_o,
   output logic [NZONE*CNT_W-1:0] zmax_o
);

   zone_e      cur, zone_q;
   logic       seen_q;
   logic [7:0] run_q, run_nxt, lim, lim_eff;

   always_comb begin
      if (win_cnt_i >= thr_hi_i)      cur = ZN_HIGH;
      else if (win_cnt_i > thr_mid_i) cur = ZN_MID;
      else if (win_cnt_i > thr_lo_i)  cur = ZN_LOW;
      else                            cur = ZN_IDLE;
   end

   assign run_nxt = (seen_q && cur == zone_q) ?
                    ((run_q == 8'hFF) ? run_q : run_q + 8'd1) : 8'd1;
   assign lim     = run_lim_i[{cur, 3'b000} +: 8];
   assign lim_eff = (lim == 8'd0) ? 8'd1 : lim;
   assign set_o   = (win_done_i && run_nxt == lim_eff) ? (NZONE'(1) << cur) : '0;
   assign zone_o  = zone_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         zone_q <= ZN_IDLE;
         run_q  <= '0;
         seen_q <= 1'b0;
      end else if (win_done_i) begin
         zone_q <= cur;
         run_q  <= run_nxt;
         seen_q <= 1'b1;
      end
   end

   for (genvar z = 0; z < NZONE; z++) begin : g_max
      logic [CNT_W-1:0] mx_q;
      logic             in_z;
      assign in_z = win_done_i && (cur == zone_e'(z));
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)
            mx_q <= '0;
         else if (in_z)
            mx_q <= (max_clr_i[z] || win_cnt_i > mx_q) ? win_cnt_i : mx_q;
         else if (max_clr_i[z])
            mx_q <= '0;
      end
      assign zmax_o[z*CNT_W +: CNT_W] = mx_q;
   end

endmodule

// File: rtl/trafmon_top.sv
module trafmon_top
   import trafmon_pkg::*;
#(
   parameter int unsigned BYTE_W   = 16,
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned CNT_W    = 32,
   parameter int unsigned WIN_W    = 32,
   parameter int unsigned MB_SHIFT = 20
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              xfer_vld_i,
   input  logic [BYTE_W-1:0] xfer_bytes_i,
   input  logic              reg_we_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   output logic              irq_o
);

   if (DATA_W < 32) begin : g_bad_data
      $error("DATA_W must be at least 32");
   end
   if (ADDR_W < 12) begin : g_bad_addr
      $error("ADDR_W must be at least 12");
   end
   if (CNT_W > DATA_W || WIN_W > DATA_W) begin : g_bad_cnt
      $error("CNT_W and WIN_W must fit in DATA_W");
   end
   if (BYTE_W > CNT_W + MB_SHIFT) begin : g_bad_byte
      $error("BYTE_W wider than the byte accumulator");
   end

   logic                   mon_en, glob_en, glob_clr, cnt_clr, win_done, gpend_q;
   logic [WIN_W-1:0]       win_len;
   logic [CNT_W-1:0]       thr_hi, thr_mid, thr_lo, win_cnt;
   logic [31:0]            run_lim;
   logic [NZONE-1:0]       loc_en, loc_clr, set_w, stat_q;
   logic [1:0]             last_zone;
   logic [NZONE*CNT_W-1:0] zmax;

   trafmon_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .WIN_W(WIN_W)
   ) u_regs (
      .clk_i, .rst_ni,
      .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
      .mon_en_o(mon_en), .win_len_o(win_len),
      .thr_hi_o(thr_hi), .thr_mid_o(thr_mid), .thr_lo_o(thr_lo), .run_lim_o(run_lim),
      .loc_en_o(loc_en), .glob_en_o(glob_en),
      .loc_clr_o(loc_clr), .glob_clr_o(glob_clr), .cnt_clr_o(cnt_clr),
      .loc_stat_i(stat_q), .glob_stat_i(gpend_q), .last_zone_i(last_zone), .zmax_i(zmax)
   );

   trafmon_window #(
      .BYTE_W(BYTE_W), .CNT_W(CNT_W), .WIN_W(WIN_W), .MB_SHIFT(MB_SHIFT)
   ) u_win (
      .clk_i, .rst_ni,
      .mon_en_i(mon_en), .cnt_clr_i(cnt_clr), .tick_i,
      .xfer_vld_i, .xfer_bytes_i, .win_len_i(win_len),
      .win_done_o(win_done), .win_cnt_o(win_cnt)
   );

   trafmon_zone #(.CNT_W(CNT_W)) u_zone (
      .clk_i, .rst_ni,
      .win_done_i(win_done), .win_cnt_i(win_cnt),
      .thr_hi_i(thr_hi), .thr_mid_i(thr_mid), .thr_lo_i(thr_lo),
      .run_lim_i(run_lim), .max_clr_i(loc_clr),
      .zone_o(last_zone), .set_o(set_w), .zmax_o(zmax)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         stat_q  <= '0;
         gpend_q <= 1'b0;
      end else begin
         stat_q  <= (stat_q & ~loc_clr) | set_w;
         gpend_q <= (|(stat_q & loc_en)) | (gpend_q & ~glob_clr);
      end
   end

   assign irq_o = gpend_q & glob_en;

endmodule

// File: rtl/trafmon_chk.sv
module trafmon_chk
   import trafmon_pkg::*;
#(
   parameter int unsigned CNT_W = 32
) (
   input logic                   clk_i,
   input logic                   rst_ni,
   input logic                   mon_en,
   input logic                   win_done,
   input logic [1:0]             last_zone,
   input logic                   glob_clr,
   input logic                   glob_en,
   input logic [NZONE-1:0]       loc_en,
   input logic [NZONE-1:0]       loc_clr,
   input logic [NZONE-1:0]       stat_q,
   input logic                   irq_o,
   input logic [NZONE*CNT_W-1:0] zmax
);

   // R8
   done_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      win_done |-> $past(mon_en));

   // R3
   zone_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !win_done |=> $stable(last_zone));

   // R7
   glob_reassert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (glob_clr && glob_en && |(stat_q & loc_en)) |=> irq_o);

   for (genvar z = 0; z < NZONE; z++) begin : g_z
      // R6
      max_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !loc_clr[z] |=> zmax[z*CNT_W +: CNT_W] >= $past(zmax[z*CNT_W +: CNT_W]));
      // R5
      stat_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $fell(stat_q[z]) |-> $past(loc_clr[z]));
      // R4
      stat_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $rose(stat_q[z]) |-> $past(win_done));
   end

endmodule

bind trafmon_top trafmon_chk #(.CNT_W(CNT_W)) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .mon_en(mon_en), .win_done(win_done),
   .last_zone(last_zone), .glob_clr(glob_clr), .glob_en(glob_en),
   .loc_en(loc_en), .loc_clr(loc_clr), .stat_q(stat_q), .irq_o(irq_o), .zmax(zmax)
);

// File: tb/trafmon_top_test.sv
module trafmon_top_test;

   localparam int unsigned BW = 8;
   localparam int unsigned SH = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_fast = 1'b0;
   logic [3:0]  tdiv = '0;
   logic        tick;
   logic        vld = 1'b0;
   logic [BW-1:0] bytes = '0;
   logic        we = 1'b0;
   logic [11:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   int errors = 0;
   int checks = 0;

   always #2 clk = ~clk;
   always @(posedge clk) tdiv <= tdiv + 4'd1;
   assign tick = tick_fast ? 1'b1 : tdiv[0];

   trafmon_top #(.BYTE_W(BW), .MB_SHIFT(SH)) uut (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
      .xfer_vld_i(vld), .xfer_bytes_i(bytes),
      .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
      .reg_rdata_o(rdata), .irq_o(irq)
   );

   task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk); we = 1'b1; addr = a; wdata = d;
      @(negedge clk); we = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk); addr = a; #1 d = rdata;
   endtask

   task automatic push(input logic [BW-1:0] b);
      @(negedge clk); vld = 1'b1; bytes = b;
   endtask

   task automatic idle();
      @(negedge clk); vld = 1'b0; bytes = '0;
   endtask

   function automatic int zone_of(input int c);
      if (c >= 12) return 1;
      if (c > 8) return 2;
      if (c > 3) return 3;
      return 0;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin : main
      logic [31:0] d;
      int lim [4];
      int run, lastz, z;
      bit seen;
      logic [3:0] es;
      lim[0] = 1; lim[1] = 2; lim[2] = 1; lim[3] = 3;
      run = 0; lastz = 0; seen = 0; es = '0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R10 reset values
      rd(12'h2B8, d); chk(d == 32'h9525_0901, "R10 action reset", d, 32'h9525_0901);
      rd(12'h100, d); chk(d == 0, "R10 local status reset", d, 0);
      rd(12'h2A8, d); chk(d == 0, "R10 window reset", d, 0);
      chk(irq == 1'b0, "R10 irq reset", {31'd0, irq}, 0);

      wr(12'h2A8, 32'd40);
      wr(12'h2AC, 32'd12);
      wr(12'h2B0, 32'd8);
      wr(12'h2B4, 32'd3);
      wr(12'h2BC, 32'h0300_0201);
      wr(12'h10C, 32'h0000_00A0);
      wr(12'h00C, 32'd1);
      // R11 read-back and unmapped address
      rd(12'h2A8, d); chk(d == 40, "R11 window readback", d, 40);
      rd(12'h004, d); chk(d == 0, "R11 unmapped reads 0", d, 0);

      // R1 R2 R3 R4 sweep of per-window counts
      for (int c = 0; c < 16; c++) begin
         wr(12'h2A4, 32'd1);
         wr(12'h2A0, 32'd1);
         for (int k = 0; k < c; k++) push(8'd16);
         idle();
         repeat (90 - c) @(negedge clk);
         wr(12'h2A0, 32'd0);
         z = zone_of(c);
         if (seen && z == lastz) run = (run == 255) ? run : run + 1;
         else run = 1;
         seen = 1; lastz = z;
         if (run == lim[z]) es[z] = 1'b1;
         rd(12'h2D8, d); chk(d[1:0] == z[1:0], "R3 zone of window", d, z);
         rd(12'h100, d); chk(d[7:4] == es, "R4 local status", {28'd0, d[7:4]}, {28'd0, es});
      end

      // R6 per-zone maxima after sweep
      rd(12'h2E0, d); chk(d == 3,  "R6 max zone0", d, 3);
      rd(12'h2E4, d); chk(d == 15, "R6 max zone1", d, 15);
      rd(12'h2E8, d); chk(d == 11, "R6 max zone2", d, 11);
      rd(12'h2EC, d); chk(d == 8,  "R6 max zone3", d, 8);

      // R7 global aggregation, re-assert, ordered clearing
      chk(irq == 1'b1, "R7 irq with enabled pending", {31'd0, irq}, 1);
      rd(12'h000, d); chk(d == 1, "R7 global status", d, 1);
      wr(12'h008, 32'd1);
      repeat (2) @(negedge clk);
      chk(irq == 1'b1, "R7 global re-asserts while local pending", {31'd0, irq}, 1);
      wr(12'h108, 32'h0000_00A0);
      rd(12'h100, d); chk(d == 32'h50, "R5 selective local clear", d, 32'h50);
      chk(irq == 1'b1, "R7 global stays until its own clear", {31'd0, irq}, 1);
      wr(12'h008, 32'd1);
      repeat (2) @(negedge clk);
      chk(irq == 1'b0, "R7 irq low after ordered clear", {31'd0, irq}, 0);
      wr(12'h10C, 32'h0000_00E0);
      repeat (2) @(negedge clk);
      chk(irq == 1'b1, "R7 enabling a pending zone raises irq", {31'd0, irq}, 1);
      wr(12'h108, 32'h0000_00F0);
      wr(12'h008, 32'd1);
      repeat (2) @(negedge clk);
      chk(irq == 1'b0, "R7 irq low after full clear", {31'd0, irq}, 0);

      // R5 max zeroed by local clear; R8 traffic ignored while disabled
      rd(12'h2E4, d); chk(d == 0, "R5 max cleared with status", d, 0);
      for (int k = 0; k < 15; k++) push(8'd16);
      idle();
      repeat (200) @(negedge clk);
      rd(12'h2E4, d); chk(d == 0, "R8 no window while disabled", d, 0);
      rd(12'h100, d); chk(d == 0, "R8 status unchanged while disabled", d, 0);

      // R9 counter clear mid-window
      wr(12'h2A4, 32'd1);
      wr(12'h2A0, 32'd1);
      for (int k = 0; k < 6; k++) push(8'd16);
      idle();
      wr(12'h2A4, 32'd1);
      push(8'd16); push(8'd16);
      idle();
      repeat (90) @(negedge clk);
      wr(12'h2A0, 32'd0);
      rd(12'h2D8, d); chk(d[1:0] == 2'd0, "R9 clear discards partial sum", d, 0);
      rd(12'h2E0, d); chk(d == 2, "R9 count after clear", d, 2);

      // R2 floor of partial unit
      wr(12'h2A4, 32'd1);
      wr(12'h2A0, 32'd1);
      for (int k = 0; k < 5; k++) push(8'd16);
      push(8'd15);
      idle();
      repeat (90) @(negedge clk);
      wr(12'h2A0, 32'd0);
      rd(12'h2EC, d); chk(d == 5, "R2 partial unit truncated", d, 5);

      // R2 strobe in the window-closing cycle, one-tick windows
      wr(12'h108, 32'h0000_00F0);
      tick_fast = 1'b1;
      wr(12'h2A8, 32'd1);
      wr(12'h2A4, 32'd1);
      wr(12'h2A0, 32'd1);
      push(8'd144);
      push(8'd208);
      idle();
      wr(12'h2A0, 32'd0);
      tick_fast = 1'b0;
      rd(12'h2E8, d); chk(d == 9,  "R2 strobe kept in closing window (zone2)", d, 9);
      rd(12'h2E4, d); chk(d == 13, "R2 next strobe in its own window (zone1)", d, 13);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule